// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared bus. It uses a write-update scheme: other caches' copies are refreshed in place, never invalidated. Each line holds one word. A valid line is in one of three states. Exclusive-clean means unmodified and the only cached copy. Shared-clean means unmodified and possibly held elsewhere. Dirty means modified and the only copy. A separate valid bit per line marks a line as empty.

The processor side has a request stream and a response stream, each with valid/ready. A request must be held stable while `cpu_req_valid` is high and `cpu_req_ready` is low. The response is held stable until `cpu_rsp_ready` is seen high. No new request is accepted while a response is waiting. Requests that need the bus raise `bus_req` and issue exactly one command in each cycle in which `bus_gnt` is high. The bus is single-cycle: read data (`bus_rdata`) and the wired-OR sharing signal (`shared_in`) are sampled at the end of that same cycle.

The snoop side watches other masters' commands. It asserts `shared_out` in the same cycle whenever it holds the snooped word. It supplies dirty data for a snooped read, and it copies the data of a snooped update into its own line. The environment never presents a snoop in a cycle in which this controller holds the grant.

Top module: `wu_snoop_ctrl`

## Requirements
- R1: After reset no line is valid, `cpu_req_ready` is high when no snoop is present, and `bus_req`, `cpu_rsp_valid`, `mst_cmd` and `shared_out` are low.
- R2: A read that hits returns the stored word with `cpu_rsp_valid` in the cycle after acceptance, with no bus request.
- R3: A write that hits a dirty or exclusive-clean line completes locally: the response (carrying the written word) comes in the cycle after acceptance, no bus request is raised, and the line becomes dirty.
- R4: A write that hits a shared-clean line raises `bus_req`. On grant it issues one update command (`mst_cmd`=2) with the request address and data, and then responds.
- R5: After an update, the writer's line is shared-clean if `shared_in` was high in the grant cycle and exclusive-clean otherwise. A later write then takes the bus or stays local accordingly.
- R6: A read miss issues a read command (`mst_cmd`=1) on grant and fills the line from `bus_rdata`. The line becomes shared-clean if `shared_in` was high and exclusive-clean otherwise. The response carries the fetched word.
- R7: A write miss first performs the fill. If `shared_in` was low, the write is applied locally, the line becomes dirty and the response follows. If it was high, the line becomes shared-clean and a second grant issues an update.
- R8: A miss whose victim line is dirty first issues a write-back (`mst_cmd`=3) of the victim's address ({tag, index}) and data, and then the read. If a snooped read has made the victim shared-clean before the grant, no write-back is issued.
- R9: `shared_out` is high in the cycle of a snooped read (`snp_cmd`=1) or update (`snp_cmd`=2) whose address matches a valid line. It is low for snooped write-backs (`snp_cmd`=3), for non-matching addresses and when no snoop is present.
- R10: A snooped update that matches a valid line replaces the line's data with `snp_wdata` and leaves it shared-clean.
- R11: A snooped read that matches a dirty line raises `supply_valid` with the line's word on `supply_data` in the same cycle. A matching line of any clean or dirty state becomes shared-clean.
- R12: In any cycle with `snp_valid` high, `cpu_req_ready` is low, so the snoop takes the line storage first. A pending response stays valid and stable until accepted.

Address fields: the low log2(LINES) bits of a word address select the line and the remaining bits form the tag. Bus command codes: 0 none, 1 read, 2 update (write-through), 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor accepts response |
| cpu_rsp_rdata | output | DATA_W | Read word, or written word for writes |
| bus_req | output | 1 | Bus requested |
| bus_gnt | input | 1 | Grant for one command this cycle |
| mst_cmd | output | 2 | Issued command, 0 when idle |
| mst_addr | output | ADDR_W | Command address |
| mst_wdata | output | DATA_W | Data for update or write-back |
| bus_rdata | input | DATA_W | Read data in the read cycle |
| shared_in | input | 1 | Wired-OR sharing signal from the other caches |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped update data |
| shared_out | output | 1 | This cache holds the snooped word |
| supply_valid | output | 1 | Dirty data supplied for a snooped read |
| supply_data | output | DATA_W | Supplied word |

## Verification
The processor path and the snoop path both reach the same line storage. A snooped command can arrive in the very cycle a processor request is presented, and while a miss waits for its grant. The bench draws addresses from six words that fall on two lines, and it injects snoops at random in every non-grant cycle. Requests therefore often meet a snoop to their own line: a snooped read can turn a dirty victim shared-clean just before its write-back would be issued, and an update can land on a line waiting for its own write-through. A behavioural model predicts the stalls, the commands and the data on every clock, and compares them with the outputs.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    LS_VEX    = 2'd0,
    LS_SHARED = 2'd1,
    LS_DIRTY  = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/wu_line_store.sv
module wu_line_store
  import wu_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output line_st_e          ra_state,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output line_st_e          rb_state,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wa_we,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [TAG_W-1:0]  wa_tag,
  input  line_st_e          wa_state,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  line_st_e          wb_state,
  input  logic [DATA_W-1:0] wb_data
);
  logic              v_arr [LINES];
  logic [TAG_W-1:0]  t_arr [LINES];
  line_st_e          s_arr [LINES];
  logic [DATA_W-1:0] d_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    line_st_e          s_q;
    logic [DATA_W-1:0] d_q;
    logic              sel_a, sel_b;

    assign sel_a = wa_we && (wa_idx == IDX_W'(i));
    assign sel_b = wb_we && (wb_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        s_q <= LS_VEX;
        d_q <= '0;
      end else if (sel_b) begin
        s_q <= wb_state;
        d_q <= wb_data;
      end else if (sel_a) begin
        v_q <= 1'b1;
        t_q <= wa_tag;
        s_q <= wa_state;
        d_q <= wa_data;
      end
    end

    assign v_arr[i] = v_q;
    assign t_arr[i] = t_q;
    assign s_arr[i] = s_q;
    assign d_arr[i] = d_q;
  end

  assign ra_valid = v_arr[ra_idx];
  assign ra_tag   = t_arr[ra_idx];
  assign ra_state = s_arr[ra_idx];
  assign ra_data  = d_arr[ra_idx];
  assign rb_valid = v_arr[rb_idx];
  assign rb_tag   = t_arr[rb_idx];
  assign rb_state = s_arr[rb_idx];
  assign rb_data  = d_arr[rb_idx];

  // the snoop port and the processor port never claim storage in one cycle
  assert_one_writer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_we && wb_we));
endmodule

// File: rtl/wu_snoop_unit.sv
module wu_snoop_unit
  import wu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic [IDX_W-1:0]  rb_idx,
  input  logic              rb_valid,
  input  logic [TAG_W-1:0]  rb_tag,
  input  line_st_e          rb_state,
  input  logic [DATA_W-1:0] rb_data,
  output logic              wb_we,
  output logic [IDX_W-1:0]  wb_idx,
  output line_st_e          wb_state,
  output logic [DATA_W-1:0] wb_data,
  output logic              shared_out,
  output logic              supply_valid,
  output logic [DATA_W-1:0] supply_data
);
  logic match, is_read, is_upd;

  assign rb_idx  = snp_addr[IDX_W-1:0];
  assign match   = snp_valid && rb_valid && (rb_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign is_read = (bus_cmd_e'(snp_cmd) == BC_READ);
  assign is_upd  = (bus_cmd_e'(snp_cmd) == BC_UPDATE);

  assign shared_out   = match && (is_read || is_upd);
  assign supply_valid = match && is_read && (rb_state == LS_DIRTY);
  assign supply_data  = rb_data;

  assign wb_we    = shared_out;
  assign wb_idx   = rb_idx;
  assign wb_state = LS_SHARED;
  assign wb_data  = is_upd ? snp_wdata : rb_data;

  assert_supply_shared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    supply_valid |-> shared_out);
  // after a supplied read the line is no longer dirty
  assert_supply_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    supply_valid |=> !(snp_valid && rb_idx == $past(rb_idx) && rb_state == LS_DIRTY));
endmodule

// File: rtl/wu_req_fsm.sv
module wu_req_fsm
  import wu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shared_in,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  ra_idx,
  input  logic              ra_valid,
  input  logic [TAG_W-1:0]  ra_tag,
  input  line_st_e          ra_state,
  input  logic [DATA_W-1:0] ra_data,
  output logic              wa_we,
  output logic [IDX_W-1:0]  wa_idx,
  output logic [TAG_W-1:0]  wa_tag,
  output line_st_e          wa_state,
  output logic [DATA_W-1:0] wa_data
);
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} fsm_e;

  fsm_e              st;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [DATA_W-1:0] rsp_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit, accept, issue, local_done, fill_local;
  bus_cmd_e          cmd;

  assign cur_addr   = (st == S_IDLE) ? cpu_req_addr : q_addr;
  assign ra_idx     = cur_addr[IDX_W-1:0];
  assign cur_tag    = cur_addr[ADDR_W-1:IDX_W];
  assign hit        = ra_valid && (ra_tag == cur_tag);

  assign cpu_req_ready = (st == S_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign local_done    = accept && hit && (!cpu_req_write || ra_state != LS_SHARED);
  assign issue         = (st == S_BUS) && bus_gnt;
  assign fill_local    = !(q_write && shared_in);

  always_comb begin
    cmd = BC_NONE;
    if (issue) begin
      if (hit)                                  cmd = BC_UPDATE;
      else if (ra_valid && ra_state == LS_DIRTY) cmd = BC_WBACK;
      else                                      cmd = BC_READ;
    end
  end

  assign mst_cmd   = cmd;
  assign mst_addr  = (cmd == BC_WBACK) ? {ra_tag, ra_idx} : q_addr;
  assign mst_wdata = (cmd == BC_WBACK) ? ra_data : q_wdata;
  assign bus_req   = (st == S_BUS);

  always_comb begin
    wa_we    = 1'b0;
    wa_idx   = ra_idx;
    wa_tag   = cur_tag;
    wa_state = ra_state;
    wa_data  = ra_data;
    if (local_done && cpu_req_write) begin
      wa_we    = 1'b1;
      wa_state = LS_DIRTY;
      wa_data  = cpu_req_wdata;
    end else begin
      case (cmd)
        BC_UPDATE: begin
          wa_we    = 1'b1;
          wa_state = shared_in ? LS_SHARED : LS_VEX;
          wa_data  = q_wdata;
        end
        BC_WBACK: begin
          wa_we    = 1'b1;
          wa_tag   = ra_tag;
          wa_state = LS_VEX;
        end
        BC_READ: begin
          wa_we    = 1'b1;
          wa_state = shared_in ? LS_SHARED : (q_write ? LS_DIRTY : LS_VEX);
          wa_data  = (q_write && !shared_in) ? q_wdata : bus_rdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      q_write <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      rsp_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          q_write <= cpu_req_write;
          q_addr  <= cpu_req_addr;
          q_wdata <= cpu_req_wdata;
          if (local_done) begin
            rsp_q <= cpu_req_write ? cpu_req_wdata : ra_data;
            st    <= S_RESP;
          end else begin
            st <= S_BUS;
          end
        end
        S_BUS: begin
          if (cmd == BC_UPDATE) begin
            rsp_q <= q_wdata;
            st    <= S_RESP;
          end else if (cmd == BC_READ && fill_local) begin
            rsp_q <= q_write ? q_wdata : bus_rdata;
            st    <= S_RESP;
          end
        end
        S_RESP: if (cpu_rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_rsp_valid = (st == S_RESP);
  assign cpu_rsp_rdata = rsp_q;

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));
  assert_local_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && cpu_req_write && ra_state == LS_DIRTY) |=> (cpu_rsp_valid && !bus_req));
  assert_update_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_cmd == BC_UPDATE) |-> (ra_state == LS_SHARED));
  assert_wback_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_cmd == BC_WBACK) |=> (bus_req && !cpu_rsp_valid));
  assert_no_snoop_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !(bus_req && bus_gnt));
endmodule

// File: rtl/wu_snoop_ctrl.sv
module wu_snoop_ctrl
  import wu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              shared_out,
  output logic              supply_valid,
  output logic [DATA_W-1:0] supply_data
);
  logic [IDX_W-1:0]  ra_idx, rb_idx, wa_idx, wb_idx;
  logic              ra_valid, rb_valid, wa_we, wb_we;
  logic [TAG_W-1:0]  ra_tag, rb_tag, wa_tag;
  line_st_e          ra_state, rb_state, wa_state, wb_state;
  logic [DATA_W-1:0] ra_data, rb_data, wa_data, wb_data;

  wu_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_valid(ra_valid), .ra_tag(ra_tag), .ra_state(ra_state), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_state(rb_state), .rb_data(rb_data),
    .wa_we(wa_we), .wa_idx(wa_idx), .wa_tag(wa_tag), .wa_state(wa_state), .wa_data(wa_data),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_state(wb_state), .wb_data(wb_data)
  );

  wu_snoop_unit #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .rb_idx(rb_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_state(rb_state), .rb_data(rb_data),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_state(wb_state), .wb_data(wb_data),
    .shared_out(shared_out), .supply_valid(supply_valid), .supply_data(supply_data)
  );

  wu_req_fsm #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mst_cmd(mst_cmd), .mst_addr(mst_addr),
    .mst_wdata(mst_wdata), .bus_rdata(bus_rdata), .shared_in(shared_in), .snp_valid(snp_valid),
    .ra_idx(ra_idx), .ra_valid(ra_valid), .ra_tag(ra_tag), .ra_state(ra_state), .ra_data(ra_data),
    .wa_we(wa_we), .wa_idx(wa_idx), .wa_tag(wa_tag), .wa_state(wa_state), .wa_data(wa_data)
  );
endmodule

// File: tb/wu_snoop_ctrl_tb.sv
`timescale 1ns/100ps
module wu_snoop_ctrl_tb;
  localparam int AW = 10, DW = 32, NL = 8;
  localparam int NCYC = 8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, bus_req, shared_out, supply_valid;
  logic [DW-1:0] cpu_rsp_rdata, mst_wdata, supply_data;
  logic [1:0] mst_cmd;
  logic [AW-1:0] mst_addr;
  logic bus_gnt = 0, shared_in = 0, snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_wdata = '0, bus_rdata = '0;

  always #2.5 clk = ~clk;

  wu_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mst_cmd(mst_cmd), .mst_addr(mst_addr),
    .mst_wdata(mst_wdata), .bus_rdata(bus_rdata), .shared_in(shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .shared_out(shared_out), .supply_valid(supply_valid), .supply_data(supply_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  // behavioural reference: line states 0 excl-clean, 1 shared, 2 dirty
  bit          mv [NL];
  int          mtag [NL];
  int          mst [NL];
  logic [DW-1:0] mdat [NL];
  bit          mflag [NL];   // state was set by a write-through sharing sample
  bit          msnp [NL];    // data came from a snooped update
  logic [DW-1:0] mem [1 << AW];
  int          mfsm = 0;     // 0 idle, 1 waiting for bus, 2 responding
  bit          q_write = 0;
  int          q_addr = 0;
  logic [DW-1:0] q_wdata = '0, rsp_exp = '0;
  string       op_tag = "R1";
  bit          g = 0, pending = 0;

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int pool_addr(input logic [31:0] r);
    int t, ix;
    t  = int'(r % 3);
    ix = ((r / 3) % 2 == 1) ? 5 : 0;
    return t * NL + ix;
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h55;
    for (int i = 0; i < NL; i++) begin
      mv[i] = 0; mtag[i] = 0; mst[i] = 0; mdat[i] = '0; mflag[i] = 0; msnp[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = '0;
    #1;
    chk(32'(shared_out), 0, "R1", "shared_out with empty lines");
    chk(32'(cpu_req_ready), 0, "R12", "ready during snoop");
    snp_valid = 0;
    #1;
    chk(32'(cpu_req_ready), 1, "R1", "ready after reset");
    chk(32'(bus_req), 0, "R1", "bus_req after reset");
    chk(32'(cpu_rsp_valid), 0, "R1", "rsp_valid after reset");
    chk(32'(mst_cmd), 0, "R1", "mst_cmd after reset");

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // ---- stimulus ----
      bus_gnt = g;
      if (!g && (rnd() % 4 == 0)) begin
        snp_valid = 1;
        snp_cmd   = 2'(1 + rnd() % 3);
        snp_addr  = AW'(pool_addr(rnd()));
        snp_wdata = rnd();
      end else begin
        snp_valid = 0;
      end
      if (!pending && (rnd() % 2 == 0)) begin
        pending       = 1;
        cpu_req_write = rnd() % 2 == 1;
        cpu_req_addr  = AW'(pool_addr(rnd()));
        cpu_req_wdata = rnd();
      end
      cpu_req_valid = pending;
      shared_in     = rnd() % 2 == 1;
      cpu_rsp_ready = (rnd() % 4) != 0;
      bus_rdata     = mem[q_addr];
      #1;
      begin
        bit e_ready, e_req, issue, hit, shit, e_sh, e_sup, acc;
        int qi, qt, si, stg, e_cmd, e_addr;
        logic [DW-1:0] e_wd;
        string ctag;
        e_ready = (mfsm == 0) && !snp_valid;
        e_req   = (mfsm == 1);
        issue   = e_req && g;
        qi = q_addr % NL; qt = q_addr / NL;
        hit = mv[qi] && (mtag[qi] == qt);
        e_cmd = 0; e_addr = q_addr; e_wd = q_wdata; ctag = op_tag;
        if (issue) begin
          if (hit) begin e_cmd = 2; ctag = (op_tag == "R7") ? "R7" : "R4"; end
          else if (mv[qi] && mst[qi] == 2) begin
            e_cmd = 3; e_addr = mtag[qi] * NL + qi; e_wd = mdat[qi]; ctag = "R8";
          end else begin e_cmd = 1; ctag = (op_tag == "R7") ? "R7" : "R6"; end
        end
        si = int'(snp_addr) % NL; stg = int'(snp_addr) / NL;
        shit  = snp_valid && mv[si] && (mtag[si] == stg);
        e_sh  = shit && (snp_cmd == 2'd1 || snp_cmd == 2'd2);
        e_sup = shit && (snp_cmd == 2'd1) && (mst[si] == 2);

        // ---- compare ----
        chk(32'(cpu_req_ready), 32'(e_ready), "R12", "cpu_req_ready");
        chk(32'(cpu_rsp_valid), 32'(mfsm == 2), op_tag, "cpu_rsp_valid");
        if (mfsm == 2) chk(cpu_rsp_rdata, rsp_exp, op_tag, "cpu_rsp_rdata");
        chk(32'(bus_req), 32'(e_req), op_tag, "bus_req");
        chk(32'(mst_cmd), 32'(e_cmd), ctag, "mst_cmd");
        if (e_cmd != 0) chk(32'(mst_addr), 32'(e_addr), ctag, "mst_addr");
        if (e_cmd >= 2) chk(mst_wdata, e_wd, ctag, "mst_wdata");
        chk(32'(shared_out), 32'(e_sh), "R9", "shared_out");
        chk(32'(supply_valid), 32'(e_sup), "R11", "supply_valid");
        if (e_sup) chk(supply_data, mdat[si], "R11", "supply_data");

        // ---- advance the model by one clock ----
        acc = pending && e_ready;
        if (snp_valid && (snp_cmd == 2'd2 || snp_cmd == 2'd3)) mem[snp_addr] = snp_wdata;
        if (e_sup) mem[snp_addr] = mdat[si];
        if (e_sh) begin
          if (snp_cmd == 2'd2) begin mdat[si] = snp_wdata; msnp[si] = 1; end
          mst[si] = 1; mflag[si] = 0;
        end
        case (mfsm)
          0: if (acc) begin
            int ai, at;
            bit ah;
            ai = int'(cpu_req_addr) % NL; at = int'(cpu_req_addr) / NL;
            ah = mv[ai] && (mtag[ai] == at);
            q_write = cpu_req_write; q_addr = int'(cpu_req_addr); q_wdata = cpu_req_wdata;
            if (ah && (!cpu_req_write || mst[ai] != 1)) begin
              if (cpu_req_write) begin
                op_tag = mflag[ai] ? "R5" : "R3";
                mdat[ai] = cpu_req_wdata; mst[ai] = 2; msnp[ai] = 0; mflag[ai] = 0;
                rsp_exp = cpu_req_wdata;
              end else begin
                op_tag = msnp[ai] ? "R10" : "R2";
                rsp_exp = mdat[ai];
              end
              mfsm = 2;
            end else begin
              if (ah) op_tag = mflag[ai] ? "R5" : "R4";
              else if (mv[ai] && mst[ai] == 2) op_tag = "R8";
              else op_tag = cpu_req_write ? "R7" : "R6";
              mfsm = 1;
            end
          end
          1: if (issue) begin
            if (e_cmd == 2) begin
              mem[q_addr] = q_wdata;
              mdat[qi] = q_wdata; mst[qi] = shared_in ? 1 : 0; mflag[qi] = 1; msnp[qi] = 0;
              rsp_exp = q_wdata; mfsm = 2;
            end else if (e_cmd == 3) begin
              mem[e_addr] = mdat[qi]; mst[qi] = 0;
            end else begin
              logic [DW-1:0] rd;
              rd = mem[q_addr];
              mv[qi] = 1; mtag[qi] = qt; msnp[qi] = 0; mflag[qi] = 0;
              if (q_write && !shared_in) begin
                mdat[qi] = q_wdata; mst[qi] = 2; rsp_exp = q_wdata; mfsm = 2;
              end else if (q_write) begin
                mdat[qi] = rd; mst[qi] = 1;
              end else begin
                mdat[qi] = rd; mst[qi] = shared_in ? 1 : 0; rsp_exp = rd; mfsm = 2;
              end
            end
          end
          default: if (cpu_rsp_ready) mfsm = 0;
        endcase
        g = e_req && !g && (rnd() % 3 != 0);
        if (mfsm != 1) g = 0;
        if (acc) pending = 0;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule